// File: doc/BRIEF.md
# Peripheral Control Register Bank with Programmable Wait States

This block sits on a low-speed peripheral bus as a completer and holds a small bank of 32-bit control words. A requester opens each transfer with one cycle in which the select input is high and the enable input is low. It then holds enable high until the block answers by raising its ready output. The address input is a word index into the bank. Reads return the addressed word, and writes replace it.

Word 0 is the timing control word. Its low `WAIT_W` bits give the number of extra access cycles the block holds ready low before it completes a transfer. The count is captured when a transfer leaves its first cycle. A new value written to word 0 therefore governs the next transfer, not the one that carries it. Any index at or above `NUM_REGS` is refused with an error response, for reads and writes alike. So is a write to a word flagged read-only in `RO_MASK`. Read-only words return a constant built from `RO_SEED`. The error output is raised only in the completing cycle, and a refused write leaves every word as it was. Ready, read data and error all come straight from flops.

Top module: `regbank_apb_tgt`

## Requirements
- R1: After synchronous reset, rdy_o, err_o and rdata_o are 0, all writable words read 0, and the wait field of word 0 equals `WAIT_RST` (default 0).
- R2: A write to an in-range writable index stores wdata_i at the clock edge that ends its completing cycle, and a later read of that index returns it.
- R3: With wait field value N in word 0, the access phase shows exactly N cycles with rdy_o low and then one cycle with rdy_o high; rdy_o is low again in the next cycle.
- R4: With a wait field of 0, rdy_o is high in the first access cycle, so the transfer takes two cycles.
- R5: For a read, rdata_o holds the addressed word in the cycle where rdy_o is high.
- R6: An index of `NUM_REGS` (8) or more, read or write, completes with err_o high, and no word changes.
- R7: Indices 6 and 7 are read-only. They read `RO_SEED`+index (0xC0DE0006 and 0xC0DE0007) with err_o low. A write to either completes with err_o high and leaves the word unchanged.
- R8: err_o is low in every cycle where rdy_o is low, including setup and wait cycles.
- R9: The wait count is sampled when a transfer enters the access phase. A write to word 0 changes the count only from the following transfer on.
- R10: Cycles with sel_i low cause no response and no write, whatever en_i, wr_i, addr_i and wdata_i carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Completer selected for a transfer |
| en_i | input | 1 | High in the second and later cycles of a transfer |
| wr_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | ADDR_W | Word index |
| wdata_i | input | DATA_W | Write data |
| rdy_o | output | 1 | Transfer completes in this cycle |
| rdata_o | output | DATA_W | Read data, valid while rdy_o is high on a read |
| err_o | output | 1 | Completing transfer failed |

## Verification
The first access cycle begins at the edge that samples the setup cycle, and rdy_o, err_o and rdata_o are all registered. With wait count N, the response is therefore due N+1 edges after the setup edge. The bench drives every input and samples every output one time unit after a rising edge. In each access cycle it counts the cycles with rdy_o low until rdy_o rises. It compares that count with the wait field it last wrote, and reads data and error only in the cycle where rdy_o is high. At each following setup cycle it confirms that rdy_o and err_o have dropped. It checks effects on the stored words with a read-back transfer.

// File: rtl/rb_pkg.sv
package rb_pkg;
  typedef enum logic [1:0] {
    ACC_OK     = 2'd0,
    ACC_RANGE  = 2'd1,
    ACC_RDONLY = 2'd2
  } acc_status_e;
endpackage

// File: rtl/rb_phase_ctrl.sv
module rb_phase_ctrl #(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              en_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic              rdy_o,
  output logic              finish_o,
  output logic              commit_o
);
  logic [WAIT_W-1:0] cnt_q;
  logic              rdy_q;
  logic              setup_c;
  logic              stall_c;

  assign setup_c  = sel_i && !en_i;
  assign stall_c  = sel_i && en_i && !rdy_q;
  // response is loaded at this edge so it is visible in the following cycle
  assign finish_o = (setup_c && (wait_i == '0)) ||
                    (stall_c && (cnt_q <= WAIT_W'(1)));
  assign commit_o = sel_i && en_i && rdy_q;
  assign rdy_o    = rdy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (setup_c) begin
      cnt_q <= wait_i;
      rdy_q <= (wait_i == '0);
    end else if (stall_c) begin
      cnt_q <= (cnt_q == '0) ? '0 : cnt_q - 1'b1;
      rdy_q <= (cnt_q <= WAIT_W'(1));
    end else begin
      rdy_q <= 1'b0;
    end
  end

  p_zero_wait_r4: assert property (@(posedge clk) disable iff (rst)
    (sel_i && !en_i && wait_i == '0) |=> rdy_q);
  p_hold_low_r3: assert property (@(posedge clk) disable iff (rst)
    (sel_i && !en_i && wait_i != '0) |=> !rdy_q);
  p_rdy_single_r3: assert property (@(posedge clk) disable iff (rst)
    (rdy_q && sel_i && en_i) |=> !rdy_q);
endmodule

// File: rtl/rb_decode.sv
module rb_decode
  import rb_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int NUM_REGS = 8,
  parameter logic [NUM_REGS-1:0] RO_MASK = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  output acc_status_e       status_o
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

  logic in_range;
  logic ro_hit;

  assign in_range = ({1'b0, addr_i} < LIMIT);

  always_comb begin
    ro_hit = 1'b0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr_i == ADDR_W'(i)) ro_hit = RO_MASK[i];
    end
  end

  always_comb begin
    if (!in_range)             status_o = ACC_RANGE;
    else if (wr_i && ro_hit)   status_o = ACC_RDONLY;
    else                       status_o = ACC_OK;
  end
endmodule

// File: rtl/rb_storage.sv
module rb_storage #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int NUM_REGS = 8,
  parameter int WAIT_W   = 3,
  parameter logic [NUM_REGS-1:0] RO_MASK = '0,
  parameter logic [WAIT_W-1:0]   WAIT_RST = '0,
  parameter logic [DATA_W-1:0]   RO_SEED  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rd_val_o,
  output logic [WAIT_W-1:0] wait_o
);
  logic [DATA_W-1:0] slot [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    if (RO_MASK[g]) begin : g_ro
      assign slot[g] = RO_SEED + DATA_W'(g);
    end else begin : g_rw
      localparam logic [DATA_W-1:0] RST_VAL =
        (g == 0) ? DATA_W'(WAIT_RST) : '0;
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk) begin
        if (rst)                                 word_q <= RST_VAL;
        else if (we_i && addr_i == ADDR_W'(g))   word_q <= wdata_i;
      end
      assign slot[g] = word_q;
    end
  end

  always_comb begin
    rd_val_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr_i == ADDR_W'(i)) rd_val_o = slot[i];
    end
  end

  assign wait_o = slot[0][WAIT_W-1:0];
endmodule

// File: rtl/rb_resp.sv
module rb_resp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              finish_i,
  input  logic              fail_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] rd_val_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      err_o   <= 1'b0;
      rdata_o <= '0;
    end else if (finish_i) begin
      err_o <= fail_i;
      if (!wr_i) rdata_o <= rd_val_i;
    end else begin
      err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/regbank_apb_tgt.sv
module regbank_apb_tgt
  import rb_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int NUM_REGS = 8,
  parameter int WAIT_W   = 3,
  parameter logic [NUM_REGS-1:0] RO_MASK  = 8'b1100_0000,
  parameter logic [WAIT_W-1:0]   WAIT_RST = '0,
  parameter logic [DATA_W-1:0]   RO_SEED  = 32'hC0DE_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rdy_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

  acc_status_e       status;
  logic              finish;
  logic              commit;
  logic              we;
  logic [WAIT_W-1:0] wait_cnt;
  logic [DATA_W-1:0] rd_val;

  rb_phase_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk(clk), .rst(rst), .sel_i(sel_i), .en_i(en_i), .wait_i(wait_cnt),
    .rdy_o(rdy_o), .finish_o(finish), .commit_o(commit)
  );

  rb_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .RO_MASK(RO_MASK)) u_dec (
    .addr_i(addr_i), .wr_i(wr_i), .status_o(status)
  );

  assign we = commit && wr_i && (status == ACC_OK);

  rb_storage #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .WAIT_W(WAIT_W),
    .RO_MASK(RO_MASK), .WAIT_RST(WAIT_RST), .RO_SEED(RO_SEED)
  ) u_store (
    .clk(clk), .rst(rst), .we_i(we), .addr_i(addr_i), .wdata_i(wdata_i),
    .rd_val_o(rd_val), .wait_o(wait_cnt)
  );

  rb_resp #(.DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst(rst), .finish_i(finish), .fail_i(status != ACC_OK),
    .wr_i(wr_i), .rd_val_i(rd_val), .rdata_o(rdata_o), .err_o(err_o)
  );

  p_err_only_ready_r8: assert property (@(posedge clk) disable iff (rst)
    err_o |-> rdy_o);
  p_range_err_r6: assert property (@(posedge clk) disable iff (rst)
    (rdy_o && sel_i && en_i && ({1'b0, addr_i} >= LIMIT)) |-> err_o);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !sel_i |=> !rdy_o);
endmodule

// File: tb/test_regbank_apb_tgt.sv
module test_regbank_apb_tgt;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        sel_i, en_i, wr_i;
  logic [3:0]  addr_i;
  logic [31:0] wdata_i;
  logic        rdy_o;
  logic [31:0] rdata_o;
  logic        err_o;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regbank_apb_tgt i_regbank_apb_tgt (
    .clk(clk), .rst(rst), .sel_i(sel_i), .en_i(en_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdy_o(rdy_o), .rdata_o(rdata_o),
    .err_o(err_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one transfer; returns read data, error flag and number of wait cycles
  task automatic xfer(input logic w, input logic [3:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output logic er, output int nw);
    int quiet_err;
    @(posedge clk); #1;
    sel_i = 1'b1; en_i = 1'b0; wr_i = w; addr_i = a; wdata_i = d;
    check(!rdy_o && !err_o, "R8", "setup cycle rdy/err", {rdy_o, err_o}, 0);
    @(posedge clk); #1;
    en_i = 1'b1;
    nw = 0; quiet_err = 0;
    while (!rdy_o && nw < 40) begin
      if (err_o) quiet_err++;
      nw++;
      @(posedge clk); #1;
    end
    check(quiet_err == 0, "R8", "err while waiting", quiet_err, 0);
    rd = rdata_o; er = err_o;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      sel_i = 1'b0; en_i = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [31:0] rd; logic er; int nw;
    check(!rdy_o && !err_o && rdata_o == 0, "R1", "outputs after reset",
          {rdy_o, err_o, rdata_o[29:0]}, 0);
    xfer(1'b0, 4'd0, 0, rd, er, nw);
    check(rd == 0 && !er, "R1", "word0 reset value", rd, 0);
    check(nw == 0, "R4", "zero wait after reset", nw, 0);
    xfer(1'b0, 4'd3, 0, rd, er, nw);
    check(rd == 0 && !er, "R1", "word3 reset value", rd, 0);
  endtask

  task automatic t_write_read;
    logic [31:0] rd; logic er; int nw;
    xfer(1'b1, 4'd2, 32'hA5A5_1234, rd, er, nw);
    check(!er && nw == 0, "R2", "write word2 response", {er, nw[30:0]}, 0);
    xfer(1'b1, 4'd5, 32'h0F0F_F0F0, rd, er, nw);
    xfer(1'b1, 4'd1, 32'hFFFF_0001, rd, er, nw);
    xfer(1'b0, 4'd2, 32'hDEAD_BEEF, rd, er, nw);
    check(rd == 32'hA5A5_1234, "R5", "read word2", rd, 32'hA5A5_1234);
    xfer(1'b0, 4'd5, 0, rd, er, nw);
    check(rd == 32'h0F0F_F0F0, "R2", "read word5 back to back", rd, 32'h0F0F_F0F0);
    xfer(1'b0, 4'd1, 0, rd, er, nw);
    check(rd == 32'hFFFF_0001 && !er, "R2", "read word1", rd, 32'hFFFF_0001);
    idle(2);
  endtask

  task automatic t_waits;
    logic [31:0] rd; logic er; int nw;
    xfer(1'b1, 4'd0, 32'd3, rd, er, nw);
    check(nw == 0, "R9", "old count on write to word0", nw, 0);
    xfer(1'b0, 4'd2, 0, rd, er, nw);
    check(nw == 3, "R3", "three wait cycles", nw, 3);
    check(rd == 32'hA5A5_1234, "R5", "read data after waits", rd, 32'hA5A5_1234);
    xfer(1'b1, 4'd0, 32'd7, rd, er, nw);
    check(nw == 3, "R9", "count fixed at access start", nw, 3);
    xfer(1'b0, 4'd0, 0, rd, er, nw);
    check(nw == 7, "R3", "seven wait cycles", nw, 7);
    check(rd == 32'd7, "R2", "word0 read back", rd, 7);
    xfer(1'b1, 4'd4, 32'h1357_9BDF, rd, er, nw);
    xfer(1'b0, 4'd4, 0, rd, er, nw);
    check(rd == 32'h1357_9BDF, "R2", "single write under waits", rd, 32'h1357_9BDF);
    xfer(1'b1, 4'd0, 32'd0, rd, er, nw);
    check(nw == 7, "R9", "seven waits while clearing", nw, 7);
    xfer(1'b0, 4'd4, 0, rd, er, nw);
    check(nw == 0, "R4", "back to zero waits", nw, 0);
    idle(1);
  endtask

  task automatic t_range;
    logic [31:0] rd; logic er; int nw;
    xfer(1'b1, 4'd9, 32'h7777_7777, rd, er, nw);
    check(er, "R6", "write index 9 error", er, 1);
    xfer(1'b0, 4'd15, 0, rd, er, nw);
    check(er, "R6", "read index 15 error", er, 1);
    xfer(1'b0, 4'd1, 0, rd, er, nw);
    check(rd == 32'hFFFF_0001 && !er, "R6", "word1 untouched by bad write", rd, 32'hFFFF_0001);
    xfer(1'b1, 4'd0, 32'd2, rd, er, nw);
    xfer(1'b0, 4'd8, 0, rd, er, nw);
    check(er && nw == 2, "R6", "error after two waits", {er, nw[30:0]}, {1'b1, 31'd2});
    xfer(1'b1, 4'd0, 32'd0, rd, er, nw);
    idle(1);
  endtask

  task automatic t_readonly;
    logic [31:0] rd; logic er; int nw;
    xfer(1'b0, 4'd6, 0, rd, er, nw);
    check(rd == 32'hC0DE_0006 && !er, "R7", "read word6", rd, 32'hC0DE_0006);
    xfer(1'b1, 4'd7, 32'h1111_2222, rd, er, nw);
    check(er, "R7", "write word7 error", er, 1);
    xfer(1'b0, 4'd7, 0, rd, er, nw);
    check(rd == 32'hC0DE_0007 && !er, "R7", "word7 unchanged", rd, 32'hC0DE_0007);
    idle(1);
  endtask

  task automatic t_ignore;
    logic [31:0] rd; logic er; int nw; int seen;
    seen = 0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      sel_i = 1'b0; en_i = k[0]; wr_i = 1'b1; addr_i = 4'd2; wdata_i = 32'h0BAD_0BAD;
      if (rdy_o || err_o) seen++;
    end
    @(posedge clk); #1;
    if (rdy_o || err_o) seen++;
    check(seen == 0, "R10", "no response while deselected", seen, 0);
    xfer(1'b0, 4'd2, 0, rd, er, nw);
    check(rd == 32'hA5A5_1234, "R10", "word2 untouched when deselected", rd, 32'hA5A5_1234);
    idle(1);
  endtask

  initial begin
    rst = 1'b1; sel_i = 1'b0; en_i = 1'b0; wr_i = 1'b0; addr_i = '0; wdata_i = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_write_read();
    t_waits();
    t_range();
    t_readonly();
    t_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule